// File: doc/BRIEF.md
# LCD Panel Bring-Up Sequencer

This block takes an LCD controller from reset release to an active display. It issues a fixed, ordered list of single-register writes through a request/acknowledge write port, which an I2C master or a similar serial master serves. Nothing is written until a start pulse arrives and a detector has seen the free-running panel clock toggle steadily. The order is fixed. The sequencer first selects internal voltage boosting and gives every display RAM location an initial nibble. It then programs the display mode, the LCD clock setting and the boost-level/contrast byte, and enables the booster. It waits a programmable settling time, then turns on the deselect output and finally the display.

The display mode, LCD clock byte and boost byte are configuration inputs, captured when start is accepted. Two mode codes cannot be used while the booster is active. When one of them is requested, the sequencer raises a sticky error and issues no write at all. The display-mode register is changed one bit per write: first the booster enable, then the deselect output, then display on. Each of these is a separate transaction.

Top module: `lcd_bringup_seq`

## Requirements
- R1: After synchronous reset (`rst` high), `wr_req`, `done` and `error` are all low.
- R2: No write is requested until `start` has been accepted and the panel clock detector reports the panel clock as running. Running means at least CLK_MIN_EDGES rising edges of `panel_clk`, with no gap between rising edges longer than CLK_TIMEOUT system clock cycles.
- R3: The first write goes to address 0x10 (mode-select register) with data 0x02, where bit 1 selects internal boosting.
- R4: Next come RAM_DEPTH display RAM writes to addresses 0x00, 0x01, … RAM_DEPTH-1 in ascending order. Each has data {4'h0, RAM_INIT}. All of them come before any display-mode write.
- R5: Mode codes 3'b001 (static) and 3'b010 (half bias) are forbidden. A start with either code raises `error` in the cycle after start. Nothing is ever written, and `error` stays high until reset. Any other code is written to address 0x11 as data {5'b0, mode}.
- R6: After the mode write, the sequencer writes `cfg_lclk` to address 0x12, then `cfg_boost` to address 0x13. The boost byte is passed through unchanged, including its gain bit 7.
- R7: The booster enable is a write to 0x11 with data {2'b00, 1'b1, 2'b00, mode}, which sets bit 5.
- R8: After the booster-enable write is acknowledged, `wr_req` stays low for exactly SETTLE_CYCLES cycles. It then rises for the deselect write to 0x11 with data {2'b01, 1'b1, 2'b00, mode}, which adds bit 6.
- R9: The display-on write to 0x11 with data {3'b111, 2'b00, mode} follows the deselect write. Each display-mode write differs from the previous display-mode write in exactly one bit.
- R10: While `wr_req` is high and `wr_ack` is low, `wr_req`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R11: `done` rises in the cycle after the display-on write is acknowledged and stays high until reset. While `done` or `error` is high, `wr_req` is low. A `start` pulse is ignored while a sequence is running or finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin bring-up (accepted only when idle) |
| panel_clk | input | 1 | Panel clock, asynchronous, observed for activity |
| cfg_mode | input | 3 | Display mode code |
| cfg_lclk | input | 8 | LCD clock register value |
| cfg_boost | input | 8 | Boost-level/contrast value, bit 7 = gain |
| wr_req | output | 1 | Write request |
| wr_addr | output | 8 | Register address of the pending write |
| wr_data | output | 8 | Data of the pending write |
| wr_ack | input | 1 | One-cycle acknowledge of the pending write |
| done | output | 1 | Display is on; sequence complete |
| error | output | 1 | Forbidden mode was requested |

## Verification
The assertions check the following on every cycle:
- requests held stable until acknowledged;
- no request before the clock detector reports activity, or after done or error;
- a quiet window of exactly the settle length after the booster enable;
- single-bit steps between display-mode writes;
- stickiness of done and error.

Only the bench's scenarios can show that the whole write list has the right addresses, data and order. The same holds for the RAM fill count, the pass-through of the boost byte with its gain bit, and rejection of each forbidden code before any write. The scenarios also cover a panel clock that is absent or too slow, and start pulses that must be ignored.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int MODE_W = 3;

    localparam logic [ADDR_W-1:0] RAM_BASE     = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_MODESEL = 8'h10;
    localparam logic [ADDR_W-1:0] ADDR_DISP    = 8'h11;
    localparam logic [ADDR_W-1:0] ADDR_LCLK    = 8'h12;
    localparam logic [ADDR_W-1:0] ADDR_BOOST   = 8'h13;

    localparam logic [DATA_W-1:0] MODESEL_INTBOOST = 8'h02;

    localparam logic [MODE_W-1:0] MODE_STATIC   = 3'b001;
    localparam logic [MODE_W-1:0] MODE_HALFBIAS = 3'b010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_CLK,
        ST_MODESEL,
        ST_RAM,
        ST_DISPMODE,
        ST_LCLK,
        ST_BOOST_CFG,
        ST_BOOST_EN,
        ST_SETTLE,
        ST_DESEL,
        ST_DISP_ON,
        ST_DONE,
        ST_ERR
    } seq_state_t;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [DATA_W-1:0] lclk;
        logic [DATA_W-1:0] boost;
    } seq_cfg_t;

    typedef struct packed {
        logic              req;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    function automatic logic mode_forbidden(input logic [MODE_W-1:0] m);
        return (m == MODE_STATIC) || (m == MODE_HALFBIAS);
    endfunction

    // Display-mode register image: bit7 display on, bit6 deselect, bit5 booster
    function automatic logic [DATA_W-1:0] disp_word(
        input logic [MODE_W-1:0] m,
        input logic              boost_on,
        input logic              desel_on,
        input logic              disp_on
    );
        return {disp_on, desel_on, boost_on, 2'b00, m};
    endfunction

endpackage

// File: rtl/lcdseq_clk_watch.sv
module lcdseq_clk_watch #(
    parameter int MIN_EDGES = 4,
    parameter int TIMEOUT   = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic panel_clk,
    output logic running
);
    localparam int EW = $clog2(MIN_EDGES + 1);
    localparam int GW = $clog2(TIMEOUT + 1);

    logic          sync1, sync2, prev;
    logic          rise;
    logic [EW-1:0] edges;
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else begin
            sync1 <= panel_clk;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    assign rise = sync2 & ~prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            edges <= '0;
            gap   <= '0;
        end else if (rise) begin
            gap <= '0;
            if (edges != EW'(MIN_EDGES))
                edges <= edges + 1'b1;
        end else if (gap == GW'(TIMEOUT)) begin
            edges <= '0;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    assign running = (edges == EW'(MIN_EDGES));

endmodule

// File: rtl/lcdseq_settle_timer.sv
module lcdseq_settle_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic last
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= CW'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CW'(1));

endmodule

// File: rtl/lcdseq_write_gen.sv
module lcdseq_write_gen
    import lcdseq_pkg::*;
#(
    parameter int       IDX_W    = 4,
    parameter bit [3:0] RAM_INIT = 4'h0
) (
    input  seq_state_t       state,
    input  logic [IDX_W-1:0] ram_idx,
    input  seq_cfg_t         cfg,
    output wr_cmd_t          cmd
);
    always_comb begin
        cmd = '{req: 1'b0, addr: '0, data: '0};
        unique case (state)
            ST_MODESEL:   cmd = '{1'b1, ADDR_MODESEL, MODESEL_INTBOOST};
            ST_RAM:       cmd = '{1'b1, RAM_BASE + ADDR_W'(ram_idx), {4'h0, RAM_INIT}};
            ST_DISPMODE:  cmd = '{1'b1, ADDR_DISP, disp_word(cfg.mode, 1'b0, 1'b0, 1'b0)};
            ST_LCLK:      cmd = '{1'b1, ADDR_LCLK, cfg.lclk};
            ST_BOOST_CFG: cmd = '{1'b1, ADDR_BOOST, cfg.boost};
            ST_BOOST_EN:  cmd = '{1'b1, ADDR_DISP, disp_word(cfg.mode, 1'b1, 1'b0, 1'b0)};
            ST_DESEL:     cmd = '{1'b1, ADDR_DISP, disp_word(cfg.mode, 1'b1, 1'b1, 1'b0)};
            ST_DISP_ON:   cmd = '{1'b1, ADDR_DISP, disp_word(cfg.mode, 1'b1, 1'b1, 1'b1)};
            default:      cmd = '{req: 1'b0, addr: '0, data: '0};
        endcase
    end

endmodule

// File: rtl/lcd_bringup_seq.sv
module lcd_bringup_seq
    import lcdseq_pkg::*;
#(
    parameter int       RAM_DEPTH     = 16,
    parameter bit [3:0] RAM_INIT      = 4'h0,
    parameter int       SETTLE_CYCLES = 20,
    parameter int       CLK_MIN_EDGES = 4,
    parameter int       CLK_TIMEOUT   = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        panel_clk,
    input  logic [2:0]  cfg_mode,
    input  logic [7:0]  cfg_lclk,
    input  logic [7:0]  cfg_boost,
    output logic        wr_req,
    output logic [7:0]  wr_addr,
    output logic [7:0]  wr_data,
    input  logic        wr_ack,
    output logic        done,
    output logic        error
);
    localparam int IDX_W = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(RAM_DEPTH - 1);

    seq_state_t       state;
    seq_cfg_t         cfg_q;
    logic [IDX_W-1:0] ram_idx;
    wr_cmd_t          cmd;
    logic             clk_ok;
    logic             accepted;
    logic             tmr_load;
    logic             tmr_last;

    lcdseq_clk_watch #(
        .MIN_EDGES (CLK_MIN_EDGES),
        .TIMEOUT   (CLK_TIMEOUT)
    ) u_watch (
        .clk       (clk),
        .rst       (rst),
        .panel_clk (panel_clk),
        .running   (clk_ok)
    );

    lcdseq_settle_timer #(
        .CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .last (tmr_last)
    );

    lcdseq_write_gen #(
        .IDX_W    (IDX_W),
        .RAM_INIT (RAM_INIT)
    ) u_gen (
        .state   (state),
        .ram_idx (ram_idx),
        .cfg     (cfg_q),
        .cmd     (cmd)
    );

    assign accepted = cmd.req & wr_ack;
    assign tmr_load = accepted & (state == ST_BOOST_EN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg_q   <= '0;
            ram_idx <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (mode_forbidden(cfg_mode)) begin
                            state <= ST_ERR;
                        end else begin
                            cfg_q <= '{mode: cfg_mode, lclk: cfg_lclk, boost: cfg_boost};
                            state <= ST_WAIT_CLK;
                        end
                    end
                end
                ST_WAIT_CLK:  if (clk_ok) state <= ST_MODESEL;
                ST_MODESEL: begin
                    if (accepted) begin
                        ram_idx <= '0;
                        state   <= ST_RAM;
                    end
                end
                ST_RAM: begin
                    if (accepted) begin
                        if (ram_idx == IDX_LAST)
                            state <= ST_DISPMODE;
                        else
                            ram_idx <= ram_idx + 1'b1;
                    end
                end
                ST_DISPMODE:  if (accepted) state <= ST_LCLK;
                ST_LCLK:      if (accepted) state <= ST_BOOST_CFG;
                ST_BOOST_CFG: if (accepted) state <= ST_BOOST_EN;
                ST_BOOST_EN:  if (accepted) state <= ST_SETTLE;
                ST_SETTLE:    if (tmr_last) state <= ST_DESEL;
                ST_DESEL:     if (accepted) state <= ST_DISP_ON;
                ST_DISP_ON:   if (accepted) state <= ST_DONE;
                ST_DONE:      state <= ST_DONE;
                ST_ERR:       state <= ST_ERR;
                default:      state <= ST_IDLE;
            endcase
        end
    end

    assign wr_req  = cmd.req;
    assign wr_addr = cmd.addr;
    assign wr_data = cmd.data;
    assign done    = (state == ST_DONE);
    assign error   = (state == ST_ERR);

endmodule

// File: rtl/lcd_bringup_chk.sv
module lcd_bringup_chk #(
    parameter int SETTLE_CYCLES = 20
) (
    input logic       clk,
    input logic       rst,
    input logic       clk_ok,
    input logic       wr_req,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       wr_ack,
    input logic       done,
    input logic       error
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);

    logic [CW-1:0] quiet;
    logic [7:0]    last_disp;
    logic          seen_disp;
    logic          disp_acc;

    assign disp_acc = wr_req && wr_ack && (wr_addr == 8'h11);

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet     <= '0;
            last_disp <= '0;
            seen_disp <= 1'b0;
        end else begin
            if (disp_acc && wr_data[5] && !wr_data[6])
                quiet <= CW'(SETTLE_CYCLES);
            else if (quiet != '0)
                quiet <= quiet - 1'b1;
            if (disp_acc) begin
                last_disp <= wr_data;
                seen_disp <= 1'b1;
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !wr_req && !done && !error);

    assert_clock_first_R2: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> clk_ok);

    assert_no_write_on_error_R5: assert property (@(posedge clk) disable iff (rst)
        error |-> !wr_req);

    assert_error_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        error |=> error);

    assert_settle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (quiet != '0) |-> !wr_req);

    assert_settle_resume_R8: assert property (@(posedge clk) disable iff (rst)
        (quiet == '0 && $past(quiet) == CW'(1)) |-> (wr_req && wr_addr == 8'h11));

    assert_single_bit_step_R9: assert property (@(posedge clk) disable iff (rst)
        (disp_acc && seen_disp) |-> ($countones(wr_data ^ last_disp) == 1));

    assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (!wr_req && !error));

endmodule

bind lcd_bringup_seq lcd_bringup_chk #(
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clk_ok  (clk_ok),
    .wr_req  (wr_req),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_ack  (wr_ack),
    .done    (done),
    .error   (error)
);

// File: tb/tb_lcd_bringup_seq.sv
`timescale 1ns/1ps
module tb_lcd_bringup_seq;

    localparam int       DEPTH  = 12;
    localparam bit [3:0] INIT   = 4'h5;
    localparam int       SETTLE = 37;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       panel_clk = 1'b0;
    logic [2:0] cfg_mode = 3'b100;
    logic [7:0] cfg_lclk = 8'h00;
    logic [7:0] cfg_boost = 8'h00;
    logic       wr_req, wr_ack = 1'b0, done, error;
    logic [7:0] wr_addr, wr_data;

    int  errors = 0;
    int  checks = 0;
    bit  pclk_en = 1'b0;
    int  pclk_half = 20;

    always #4 clk = ~clk;

    initial forever begin
        #(pclk_half);
        if (pclk_en) panel_clk = ~panel_clk;
    end

    lcd_bringup_seq #(
        .RAM_DEPTH     (DEPTH),
        .RAM_INIT      (INIT),
        .SETTLE_CYCLES (SETTLE),
        .CLK_MIN_EDGES (4),
        .CLK_TIMEOUT   (64)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .panel_clk (panel_clk),
        .cfg_mode  (cfg_mode),
        .cfg_lclk  (cfg_lclk),
        .cfg_boost (cfg_boost),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_ack    (wr_ack),
        .done      (done),
        .error     (error)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; wr_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!wr_req && !done && !error, "R1", {wr_req, done, error}, 0);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Reference model: expected write list, latency-driven acknowledges,
    // settle gap tracking; compared on every clock once writes begin.
    task automatic run_seq(input logic [2:0] m, input logic [7:0] lc, input logic [7:0] bo,
                           input int lat, input bit poke_start);
        int    qa[$];
        int    qd[$];
        string qt[$];
        int    gap = 0;
        int    latc = 0;
        int    cyc = 0;
        int    popped = 0;
        bit    begun = 0;
        qa.push_back('h10); qd.push_back('h02); qt.push_back("R3");
        for (int i = 0; i < DEPTH; i++) begin
            qa.push_back(i); qd.push_back({4'h0, INIT}); qt.push_back("R4");
        end
        qa.push_back('h11); qd.push_back({5'b0, m});      qt.push_back("R5");
        qa.push_back('h12); qd.push_back(lc);             qt.push_back("R6");
        qa.push_back('h13); qd.push_back(bo);             qt.push_back("R6");
        qa.push_back('h11); qd.push_back(8'h20 | m);      qt.push_back("R7");
        qa.push_back('h11); qd.push_back(8'h60 | m);      qt.push_back("R8");
        qa.push_back('h11); qd.push_back(8'hE0 | m);      qt.push_back("R9");
        while (qa.size() > 0 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            wr_ack = 1'b0;
            if (poke_start && popped == 5) start = 1'b1; else start = 1'b0;
            if (!begun) begin
                if (!wr_req) continue;
                begun = 1;
            end
            if (gap > 0) begin
                check(!wr_req, "R8", wr_req, 0);
                gap--;
                continue;
            end
            check(wr_req && wr_addr == qa[0][7:0] && wr_data == qd[0][7:0], qt[0],
                  {wr_req, wr_addr, wr_data}, {1'b1, qa[0][7:0], qd[0][7:0]});
            if (wr_req) begin
                if (latc >= lat) begin
                    wr_ack = 1'b1;
                    latc = 0;
                    popped++;
                    if (qt[0] == "R7") gap = SETTLE;
                    void'(qa.pop_front()); void'(qd.pop_front()); void'(qt.pop_front());
                end else begin
                    latc++;
                end
            end
        end
        check(qa.size() == 0, "R11", qa.size(), 0);
        @(negedge clk);
        wr_ack = 1'b0; start = 1'b0;
        check(done && !wr_req && !error, "R11", {done, wr_req, error}, 3'b100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Scenario 1: reset, then start with no panel clock
        do_reset();
        cfg_mode = 3'b100; cfg_lclk = 8'h3C; cfg_boost = 8'h0A;
        pulse_start();
        begin
            bit quiet = 1;
            repeat (200) begin
                @(negedge clk);
                if (wr_req) quiet = 0;
            end
            check(quiet, "R2 no clock", !quiet, 0);
        end
        // Panel clock too slow: gaps exceed the timeout
        pclk_half = 1000; pclk_en = 1'b1;
        begin
            bit quiet = 1;
            repeat (2000) begin
                @(negedge clk);
                if (wr_req) quiet = 0;
            end
            check(quiet, "R2 slow clock", !quiet, 0);
        end
        pclk_half = 20;
        run_seq(3'b100, 8'h3C, 8'h0A, 0, 0);
        // Start after done is ignored
        pulse_start();
        begin
            bit ok = 1;
            repeat (60) begin
                @(negedge clk);
                if (wr_req || !done) ok = 0;
            end
            check(ok, "R11 start ignored when done", !ok, 0);
        end

        // Scenario 2: other mode, gain bit set, slow acks, start mid-sequence
        do_reset();
        cfg_mode = 3'b011; cfg_lclk = 8'hA5; cfg_boost = 8'h87;
        pulse_start();
        run_seq(3'b011, 8'hA5, 8'h87, 2, 1);

        // Scenario 3: config changes after start do not matter
        do_reset();
        cfg_mode = 3'b111; cfg_lclk = 8'h01; cfg_boost = 8'hFF;
        pulse_start();
        cfg_mode = 3'b001; cfg_lclk = 8'h00; cfg_boost = 8'h00;
        run_seq(3'b111, 8'h01, 8'hFF, 1, 0);

        // Scenario 4: forbidden modes
        for (int k = 0; k < 2; k++) begin
            logic [2:0] bad;
            bad = (k == 0) ? 3'b001 : 3'b010;
            do_reset();
            cfg_mode = bad;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(error && !wr_req && !done, "R5 error next cycle", {error, wr_req, done}, 3'b100);
            begin
                bit ok = 1;
                repeat (300) begin
                    @(negedge clk);
                    if (wr_req || !error) ok = 0;
                end
                check(ok, "R5 sticky, no writes", !ok, 0);
            end
        end
        do_reset();

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule